// File: doc/BRIEF.md
# Event Sequence Order Monitor

The block watches a small group of sampled signals and follows a programmed chain of transition events. Each step of the chain names a signal, the kind of transition expected on it and how the step relates to the step before it: it may be required as the very next event, allowed to arrive after other activity, combined with a second event in the same cycle, offered as one of two alternatives, or paired with a second event in either order. When the final step is reached the block pulses `match_o` for one cycle and starts over. When an ordering rule is broken it pulses `viol_o` for one cycle and returns to the first step.

Progress through the chain is driven only by events. Idle cycles between events never advance or break anything, so the block checks the order of events and not their timing. Each step carries an ignore mask, so signals that are not of interest for that step neither advance nor break it. A typical use is checking a memory write handshake: address change, write enable rising, data change, write enable falling, address change and data change, each one required as the next event.

Top module: `esm_order_monitor`

## Requirements
- R1: Signal k occupies bits [4k+3:4k] of `sig_i`. A value that is present at rising edge n is compared with the value sampled at edge n-1, and any resulting flag is visible after edge n+1.
- R2: While `rst_n_i` is low, both flags are low, the position is step 0 and every step entry is all zeros. The first two samples after reset release are never treated as events, so a nonzero input held across reset produces no match.
- R3: A write with `cfg_we_i` high stores `cfg_wdata_i` into step `cfg_addr_i` and sends the position back to step 0 with both flags low. The field layout is: link [22:20], signal A [19:17], kind A [16:14], signal B [13:11], kind B [10:8], ignore mask [7:0]. Bit j of the mask set means that signal j is ignored.
- R4: The event kinds are: 0 bit 0 rises, 1 bit 0 falls, 2 the value leaves zero, 3 the value arrives at all ones, 4 any bit changes, 5 no bit changes, 6 every bit changes. A signal index of NSIG or more never matches.
- R5: Link 0 (later): the step completes when event A occurs, and other events before it have no effect. Step 0 always waits in this way when its link is 1.
- R6: Link 1 (next): on a step other than 0, the first event on a non-ignored signal must be event A. Any other such event pulses `viol_o` for one cycle and returns the position to step 0.
- R7: Link 2 (together): the step completes only when events A and B occur in the same cycle.
- R8: Link 3 (alternative): the step completes when either event A or event B occurs.
- R9: Link 4 (either order): once A or B has been seen, the next non-ignored event must supply the partner, otherwise a violation occurs. Before the first of the two events arrives, other events are tolerated.
- R10: Changes on ignored signals of the current step neither advance that step nor break it.
- R11: Completing step `seq_len_i`-1 (length 1 to 6) pulses `match_o` for one cycle and rearms at step 0. Events in the completing cycle are not carried over to the next step.
- R12: A synchronous `restart_i` clears the position and both flags, leaving the step entries unchanged.
- R13: `match_o` and `viol_o` are never high together, and `viol_o` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| restart_i | input | 1 | Synchronous rearm to step 0 |
| cfg_we_i | input | 1 | Step entry write strobe |
| cfg_addr_i | input | 3 | Step entry index |
| cfg_wdata_i | input | 23 | Step entry contents |
| seq_len_i | input | 3 | Number of steps in the chain |
| sig_i | input | 16 | Four monitored signals of four bits each |
| match_o | output | 1 | One-cycle pulse when the chain completes |
| viol_o | output | 1 | One-cycle pulse when the order breaks |

## Verification
The bench drives an event that shares its cycle with the completion of the step before it. A design that carried that event forward would accept a chain that is out of order. It also pairs a partner event after an unrelated event in either-order mode, where a design that lacked the sub-state would miss the violation. It changes an ignored signal during a "next" step, which a design that ignored the mask would report as a violation. It holds a nonzero input across reset, which a design with unprimed history registers would count as a spurious rise and report as a match. Restart and step rewrites are each followed by an event that only a stale position would react to.

// File: rtl/esm_pkg.sv
package esm_pkg;

  localparam int MAX_SIG = 8;
  localparam int NKIND   = 8;

  typedef enum logic [2:0] {
    EK_RISE    = 3'd0,
    EK_FALL    = 3'd1,
    EK_LEAVE0  = 3'd2,
    EK_ARRIVE1 = 3'd3,
    EK_ANY     = 3'd4,
    EK_SAME    = 3'd5,
    EK_ALL     = 3'd6,
    EK_NEVER   = 3'd7
  } ev_kind_e;

  typedef enum logic [2:0] {
    LK_LATER     = 3'd0,
    LK_NEXT      = 3'd1,
    LK_BOTH      = 3'd2,
    LK_ONE_OF    = 3'd3,
    LK_ANY_ORDER = 3'd4
  } link_e;

  typedef struct packed {
    link_e                link;
    logic [2:0]           sig_a;
    ev_kind_e             kind_a;
    logic [2:0]           sig_b;
    ev_kind_e             kind_b;
    logic [MAX_SIG-1:0]   ign;
  } step_t;

  localparam int STEP_BITS = $bits(step_t);

endpackage

// File: rtl/esm_rst_sync.sv
module esm_rst_sync (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/esm_edge_detect.sv
module esm_edge_detect #(
  parameter int NSIG = 4,
  parameter int SIGW = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_n_i,
  input  logic [NSIG*SIGW-1:0]         sig_i,
  output logic [NSIG-1:0][7:0]         hit_o,
  output logic [NSIG-1:0]              chg_o,
  output logic                         valid_o
);
  localparam logic [SIGW-1:0] ONES = {SIGW{1'b1}};

  logic [NSIG-1:0][SIGW-1:0] samp_q, prev_q, samp_d, prev_d;
  logic [1:0]                fill_q, fill_d;
  logic                      fill_en;

  // next state
  always_comb begin
    samp_d  = sig_i;
    prev_d  = samp_q;
    fill_en = !fill_q[1];
    fill_d  = {fill_q[0], 1'b1};
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= samp_d;
      prev_q <= prev_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     fill_q <= 2'b00;
    else if (fill_en) fill_q <= fill_d;
  end

  assign valid_o = fill_q[1];

  for (genvar k = 0; k < NSIG; k++) begin : g_sig
    logic [SIGW-1:0] cur, old;
    logic            rise, fall, leave0, arrive1, any, same, all;
    assign cur     = samp_q[k];
    assign old     = prev_q[k];
    assign rise    = !old[0] &&  cur[0];
    assign fall    =  old[0] && !cur[0];
    assign leave0  = (old == '0) && (cur != '0);
    assign arrive1 = (cur == ONES) && (old != ONES);
    assign any     = (cur != old);
    assign same    = (cur == old);
    assign all     = ((cur ^ old) == ONES);
    // bit position equals the event kind code
    assign hit_o[k] = {1'b0, all, same, any, arrive1, leave0, fall, rise};
    assign chg_o[k] = any;
  end
endmodule

// File: rtl/esm_step_table.sv
module esm_step_table
  import esm_pkg::*;
#(
  parameter int NSTEP = 6,
  localparam int PW   = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  step_t         wr_data_i,
  input  logic [PW-1:0] rd_idx_i,
  output step_t         rd_o
);
  step_t tbl_q [NSTEP];

  for (genvar i = 0; i < NSTEP; i++) begin : g_entry
    logic ent_en;
    assign ent_en = wr_en_i && (wr_addr_i == PW'(i));
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    tbl_q[i] <= '0;
      else if (ent_en) tbl_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_o = '0;
    if (int'(rd_idx_i) < NSTEP) rd_o = tbl_q[rd_idx_i];
  end
endmodule

// File: rtl/esm_sequencer.sv
module esm_sequencer
  import esm_pkg::*;
#(
  parameter int NSIG  = 4,
  parameter int NSTEP = 6,
  localparam int PW   = (NSTEP > 1) ? $clog2(NSTEP) : 1,
  localparam int SW   = (NSIG > 1) ? $clog2(NSIG) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 restart_i,
  input  logic                 cfg_we_i,
  input  logic                 valid_i,
  input  logic [NSIG-1:0][7:0] hit_i,
  input  logic [NSIG-1:0]      chg_i,
  input  step_t                step_i,
  input  logic [PW-1:0]        last_i,
  output logic [PW-1:0]        pos_o,
  output logic                 match_o,
  output logic                 viol_o
);
  logic [PW-1:0]      pos_q, pos_d;
  logic               seen_a_q, seen_b_q, seen_a_d, seen_b_d;
  logic               match_q, viol_q, match_d, viol_d;
  logic               state_en;
  logic               hit_a, hit_b, mon, done, brk;
  logic               got_a, got_b, nxt_a, nxt_b;
  logic [MAX_SIG-1:0] chg_pad;

  // event lookup for the current step
  always_comb begin
    hit_a = 1'b0;
    hit_b = 1'b0;
    if (int'(step_i.sig_a) < NSIG) hit_a = hit_i[step_i.sig_a[SW-1:0]][step_i.kind_a];
    if (int'(step_i.sig_b) < NSIG) hit_b = hit_i[step_i.sig_b[SW-1:0]][step_i.kind_b];
    chg_pad = MAX_SIG'(chg_i);
    mon     = |(chg_pad & ~step_i.ign);
  end

  // step evaluation
  always_comb begin
    done  = 1'b0;
    brk   = 1'b0;
    got_a = seen_a_q | hit_a;
    got_b = seen_b_q | hit_b;
    nxt_a = seen_a_q;
    nxt_b = seen_b_q;
    case (step_i.link)
      LK_LATER:  done = hit_a;
      LK_NEXT: begin
        if (pos_q == '0) done = hit_a;
        else if (mon) begin
          done = hit_a;
          brk  = !hit_a;
        end
      end
      LK_BOTH:   done = hit_a & hit_b;
      LK_ONE_OF: done = hit_a | hit_b;
      LK_ANY_ORDER: begin
        if (got_a && got_b) done = 1'b1;
        else if ((seen_a_q || seen_b_q) && mon) brk = 1'b1;
        else begin
          nxt_a = got_a;
          nxt_b = got_b;
        end
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    pos_d    = pos_q;
    seen_a_d = seen_a_q;
    seen_b_d = seen_b_q;
    match_d  = 1'b0;
    viol_d   = 1'b0;
    state_en = restart_i | cfg_we_i | valid_i;
    if (restart_i || cfg_we_i) begin
      pos_d    = '0;
      seen_a_d = 1'b0;
      seen_b_d = 1'b0;
    end else if (valid_i) begin
      if (brk) begin
        pos_d    = '0;
        viol_d   = 1'b1;
        seen_a_d = 1'b0;
        seen_b_d = 1'b0;
      end else if (done) begin
        seen_a_d = 1'b0;
        seen_b_d = 1'b0;
        if (pos_q >= last_i) begin
          pos_d   = '0;
          match_d = 1'b1;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else begin
        seen_a_d = nxt_a;
        seen_b_d = nxt_b;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pos_q    <= '0;
      seen_a_q <= 1'b0;
      seen_b_q <= 1'b0;
    end else if (state_en) begin
      pos_q    <= pos_d;
      seen_a_q <= seen_a_d;
      seen_b_q <= seen_b_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      match_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      match_q <= match_d;
      viol_q  <= viol_d;
    end
  end

  assign pos_o   = pos_q;
  assign match_o = match_q;
  assign viol_o  = viol_q;
endmodule

// File: rtl/esm_order_monitor.sv
module esm_order_monitor
  import esm_pkg::*;
#(
  parameter int NSIG  = 4,
  parameter int SIGW  = 4,
  parameter int NSTEP = 6,
  localparam int PW   = (NSTEP > 1) ? $clog2(NSTEP) : 1,
  localparam int LW   = $clog2(NSTEP + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 restart_i,
  input  logic                 cfg_we_i,
  input  logic [PW-1:0]        cfg_addr_i,
  input  logic [STEP_BITS-1:0] cfg_wdata_i,
  input  logic [LW-1:0]        seq_len_i,
  input  logic [NSIG*SIGW-1:0] sig_i,
  output logic                 match_o,
  output logic                 viol_o
);
  logic                 rst_sync_n;
  logic [NSIG-1:0][7:0] hit;
  logic [NSIG-1:0]      chg;
  logic                 ev_valid;
  logic [PW-1:0]        pos;
  logic [PW-1:0]        last_idx;
  step_t                cur_step;

  // last step index from the programmed length, clamped to 1..NSTEP
  always_comb begin
    if (seq_len_i == '0)               last_idx = '0;
    else if (int'(seq_len_i) > NSTEP)  last_idx = PW'(NSTEP - 1);
    else                               last_idx = PW'(seq_len_i - 1'b1);
  end

  esm_rst_sync u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  esm_edge_detect #(.NSIG(NSIG), .SIGW(SIGW)) u_edge (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .sig_i   (sig_i),
    .hit_o   (hit),
    .chg_o   (chg),
    .valid_o (ev_valid)
  );

  esm_step_table #(.NSTEP(NSTEP)) u_tbl (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .wr_en_i   (cfg_we_i),
    .wr_addr_i (cfg_addr_i),
    .wr_data_i (step_t'(cfg_wdata_i)),
    .rd_idx_i  (pos),
    .rd_o      (cur_step)
  );

  esm_sequencer #(.NSIG(NSIG), .NSTEP(NSTEP)) u_seq (
    .clk_i     (clk_i),
    .rst_n_i   (rst_sync_n),
    .restart_i (restart_i),
    .cfg_we_i  (cfg_we_i),
    .valid_i   (ev_valid),
    .hit_i     (hit),
    .chg_i     (chg),
    .step_i    (cur_step),
    .last_i    (last_idx),
    .pos_o     (pos),
    .match_o   (match_o),
    .viol_o    (viol_o)
  );
endmodule

// File: rtl/esm_order_checker.sv
module esm_order_checker #(
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          restart_i,
  input logic          cfg_we_i,
  input logic          ev_valid_i,
  input logic          match_i,
  input logic          viol_i,
  input logic [PW-1:0] pos_i,
  input logic [PW-1:0] last_i
);
  a_r13_exclusive: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(match_i && viol_i));

  a_r13_viol_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    viol_i |=> !viol_i);

  a_r12_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    restart_i |=> (!match_i && !viol_i && pos_i == '0));

  a_r3_cfg_rearm: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cfg_we_i |=> (pos_i == '0 && !match_i && !viol_i));

  a_r2_no_early_flag: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ev_valid_i |=> (!match_i && !viol_i));

  a_r11_match_from_last: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    match_i |-> $past(pos_i >= last_i));

  a_r11_match_rearms: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    match_i |-> pos_i == '0);

  a_r6_viol_home: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    viol_i |-> pos_i == '0);
endmodule

bind esm_order_monitor esm_order_checker #(.PW(PW)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_sync_n),
  .restart_i  (restart_i),
  .cfg_we_i   (cfg_we_i),
  .ev_valid_i (ev_valid),
  .match_i    (match_o),
  .viol_i     (viol_o),
  .pos_i      (pos),
  .last_i     (last_idx)
);

// File: tb/esm_order_monitor_test.sv
`timescale 1ns/1ps
module esm_order_monitor_test;
  // link codes
  localparam logic [2:0] L_LATER = 3'd0, L_NEXT = 3'd1, L_BOTH = 3'd2,
                         L_ONE = 3'd3, L_ORD = 3'd4;
  // event kind codes
  localparam logic [2:0] K_RISE = 3'd0, K_FALL = 3'd1, K_LV0 = 3'd2,
                         K_AR1 = 3'd3, K_ANY = 3'd4, K_ALL = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n, restart, cfg_we;
  logic [2:0]  cfg_addr, seq_len;
  logic [22:0] cfg_wdata;
  logic [15:0] sig;
  logic        match_o, viol_o;
  int          n_chk = 0, n_bad = 0;
  bit          ended = 1'b0;

  always #2.5 clk = ~clk;

  esm_order_monitor uut (
    .clk_i(clk), .rst_n_i(rst_n), .restart_i(restart), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .seq_len_i(seq_len),
    .sig_i(sig), .match_o(match_o), .viol_o(viol_o)
  );

  // {signal word, expected match, expected violation}; reference handshake chain
  localparam logic [17:0] TBL [15] = '{
    {16'h0001, 1'b0, 1'b0},  // R5 address change starts chain
    {16'h5001, 1'b0, 1'b0},  // R10 masked signal during next step
    {16'h5011, 1'b0, 1'b0},  // R6 enable rises
    {16'h5311, 1'b0, 1'b0},  // R6 data change
    {16'h5301, 1'b0, 1'b0},  // R6 enable falls
    {16'h5302, 1'b0, 1'b0},  // R6 address change
    {16'h5402, 1'b1, 1'b0},  // R11 data change completes
    {16'h5403, 1'b0, 1'b0},  // R11 rearmed at step 0
    {16'h5503, 1'b0, 1'b1},  // R6 data before enable rise
    {16'h5513, 1'b0, 1'b0},  // R5 rise ignored while waiting at step 0
    {16'h5514, 1'b0, 1'b0},  // R5 address change
    {16'h5504, 1'b0, 1'b1},  // R6 fall instead of rise
    {16'h5515, 1'b0, 1'b0},  // R11 rise in the completing cycle
    {16'h5615, 1'b0, 1'b1},  // R11 that rise was not carried over
    {16'h6615, 1'b0, 1'b0}   // R10 masked signal at step 0
  };

  function automatic logic [22:0] mk(input logic [2:0] lk, input logic [2:0] sa,
      input logic [2:0] ka, input logic [2:0] sb, input logic [2:0] kb,
      input logic [7:0] ign);
    return {lk, sa, ka, sb, kb, ign};
  endfunction

  task automatic check(input string tag, input logic em, input logic ev);
    n_chk++;
    if (match_o !== em || viol_o !== ev) begin
      n_bad++;
      $display("FAIL %s: match/viol actual %b/%b expected %b/%b",
               tag, match_o, viol_o, em, ev);
    end
  endtask

  task automatic apply(input logic [15:0] v, input logic em, input logic ev,
                       input string tag);
    @(negedge clk) sig = v;
    @(negedge clk);
    @(negedge clk);
    check(tag, em, ev);
  endtask

  task automatic wr(input logic [2:0] a, input logic [22:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; end
    @(negedge clk) cfg_we = 1'b0;
    check("R3 flags low after write", 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; cfg_we = 1'b0; cfg_addr = '0;
    cfg_wdata = '0; seq_len = 3'd1; sig = 16'h0001;
    repeat (3) @(negedge clk);
    check("R2 flags in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R2 held input is no event", 1'b0, 1'b0);
    end
    // default entry: later link, bit 0 rise on signal 0, length 1
    apply(16'h0000, 1'b0, 1'b0, "R4 fall does not satisfy rise");
    apply(16'h0001, 1'b1, 1'b0, "R11 one-step chain matches on rise");
    apply(16'h0000, 1'b0, 1'b0, "R4 fall again no match");

    seq_len = 3'd6;
    wr(3'd0, mk(L_LATER, 3'd0, K_ANY,  3'd0, K_RISE, 8'h08));
    wr(3'd1, mk(L_NEXT,  3'd1, K_RISE, 3'd0, K_RISE, 8'h08));
    wr(3'd2, mk(L_NEXT,  3'd2, K_ANY,  3'd0, K_RISE, 8'h08));
    wr(3'd3, mk(L_NEXT,  3'd1, K_FALL, 3'd0, K_RISE, 8'h08));
    wr(3'd4, mk(L_NEXT,  3'd0, K_ANY,  3'd0, K_RISE, 8'h08));
    wr(3'd5, mk(L_NEXT,  3'd2, K_ANY,  3'd0, K_RISE, 8'h08));
    for (int i = 0; i < 15; i++) begin
      apply(TBL[i][17:2], TBL[i][1], TBL[i][0], $sformatf("R1 R6 table row %0d", i));
    end

    // together / alternative / either-order chain
    seq_len = 3'd3;
    wr(3'd0, mk(L_BOTH, 3'd1, K_RISE, 3'd0, K_ANY, 8'h08));
    wr(3'd1, mk(L_ONE,  3'd1, K_FALL, 3'd2, K_ALL, 8'h08));
    wr(3'd2, mk(L_ORD,  3'd0, K_AR1,  3'd2, K_LV0, 8'h08));
    apply(16'h6605, 1'b0, 1'b0, "R7 lone fall");
    apply(16'h6005, 1'b0, 1'b0, "R7 lone data change");
    apply(16'h6006, 1'b0, 1'b0, "R7 half of pair only");
    apply(16'h6017, 1'b0, 1'b0, "R7 both in one cycle");
    apply(16'h6007, 1'b0, 1'b0, "R8 first alternative");
    apply(16'h6307, 1'b0, 1'b0, "R9 B leaves zero first");
    apply(16'h630F, 1'b1, 1'b0, "R9 A arrives at ones, match");
    apply(16'h631E, 1'b0, 1'b0, "R7 pair again");
    apply(16'h6C1E, 1'b0, 1'b0, "R8 second alternative all bits");
    apply(16'h6C0E, 1'b0, 1'b0, "R9 unrelated before pair tolerated");
    apply(16'h6C0F, 1'b0, 1'b0, "R9 A seen");
    apply(16'h6C1F, 1'b0, 1'b1, "R9 unrelated after A breaks");

    // next link with per-step mask, and restart
    seq_len = 3'd2;
    wr(3'd0, mk(L_LATER, 3'd0, K_ANY,  3'd0, K_RISE, 8'h00));
    wr(3'd1, mk(L_NEXT,  3'd1, K_RISE, 3'd0, K_RISE, 8'h04));
    apply(16'h6C0F, 1'b0, 1'b0, "R5 other event while waiting");
    apply(16'h6C0E, 1'b0, 1'b0, "R5 step 0 done");
    apply(16'h6D0E, 1'b0, 1'b0, "R10 ignored data change");
    apply(16'h6D1E, 1'b1, 1'b0, "R6 rise is next event, match");
    apply(16'h6D1F, 1'b0, 1'b0, "R12 advance before restart");
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    check("R12 flags low after restart", 1'b0, 1'b0);
    apply(16'h6D0F, 1'b0, 1'b0, "R12 fall at step 0 harmless");
    apply(16'h6D1F, 1'b0, 1'b0, "R12 rise at step 0 no match");
    apply(16'h6D1E, 1'b0, 1'b0, "R5 step 0 done");
    apply(16'h7D1E, 1'b0, 1'b1, "R10 unmasked signal breaks next link");
    apply(16'h7D1F, 1'b0, 1'b0, "R13 no repeat violation");
    finish_run();
  end
endmodule